// File: doc/BRIEF.md
# Radix-4 Sequential Unsigned Multiplier

This block multiplies two unsigned K-bit operands and retires two multiplier bits per clock, so a product takes K/2 digit cycles. A pulse on `start` while the block is free captures both operands. One setup cycle follows, in which three times the multiplicand is formed and kept in a register. Each digit cycle then takes the two lowest bits of the remaining multiplier, adds the matching multiple to the upper half of the running product and shifts the whole product right by two places. The multiples are 0, a, 2a and 3a. The multiplier bits drain out of the low half while the product bits fill it.

A build parameter selects how a digit of value 3 is formed. In triple mode the stored 3a is added. In negate mode 3 is applied as -a with a carry of one into the next digit. That carry can turn a digit of 2 into 3, which becomes -a with a carry again, or turn a digit of 3 into 4, which becomes 0 with a carry. A carry still left after the top digit adds a·2^K, so the product stays exact. Both modes take the same number of cycles.

`done` rises when the product is ready. It stays high, with `product` held, until the next accepted `start`.

Top module: `quad_digit_mult`

## Requirements
- R1: After reset `done` is 0 and `product` is 0.
- R2: `done` rises at the (K/2+1)-th rising edge after the edge that samples an accepted `start`. That is one setup edge plus K/2 digit edges.
- R3: In triple mode (digit 3 uses the stored 3a), `product` equals a·x as an unsigned 2K-bit value once `done` is high.
- R4: In negate mode (digit 3 applied as -a plus a carry into the next digit), `product` equals a·x. This includes multipliers whose carry runs through every digit and out of the top digit, such as all ones.
- R5: While `done` is high and `start` is low, `done` stays high and `product` stays constant.
- R6: A `start` that arrives during the setup or digit cycles is ignored. The running product completes with the original operands and the original latency.
- R7: A `start` accepted while `done` is high clears `done` at the next rising edge.
- R8: The operands are sampled only on the accepting edge. Later changes on `a_in` and `x_in` have no effect on the result.
- R9: Operand extremes produce exact results in both modes: a zero operand gives 0, and all-ones times all-ones gives (2^K-1)^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a product when the block is idle or done |
| a_in | input | K | Multiplicand |
| x_in | input | K | Multiplier, K even |
| done | output | 1 | Product valid, held until the next accepted start |
| product | output | 2K | Unsigned product a·x |

## Verification
The bench builds two copies of the block with K = 8, one in triple mode and one in negate mode, and feeds both the same stimulus. With K = 8 the block runs four digit cycles per product. This makes every digit value and every carry case cheap to reach: a run of all-ones multiplier bits carries through all four digits and out of the top. The eight-bit operand space is small enough that a few hundred pseudo-random pairs, together with the extremes, cover each digit value at each position many times. Both copies must agree on latency, so a difference in the setup or digit count between the modes would show up at once.

// File: rtl/qdm_pkg.sv
package qdm_pkg;

    // Phases of one multiplication
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_RUN   = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    // How a radix-4 digit of value 3 is realised
    typedef enum logic {
        SEL_TRIPLE = 1'b0,   // add the stored 3a
        SEL_NEGATE = 1'b1    // subtract a, carry one into the next digit
    } sel_mode_e;

endpackage

// File: rtl/qdm_seq.sv
module qdm_seq
    import qdm_pkg::*;
#(
    parameter int NDIG = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_e phase,
    output logic   accept,
    output logic   last_digit
);

    localparam int CW = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(NDIG - 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        accept     = start && ((seq_q.phase == PH_IDLE) || (seq_q.phase == PH_DONE));
        last_digit = (seq_q.phase == PH_RUN) && (seq_q.cnt == LAST_IDX);
        unique case (seq_q.phase)
            PH_IDLE, PH_DONE: begin
                if (accept) begin
                    seq_d.phase = PH_SETUP;
                    seq_d.cnt   = '0;
                end
            end
            PH_SETUP: begin
                seq_d.phase = PH_RUN;
                seq_d.cnt   = '0;
            end
            PH_RUN: begin
                if (last_digit) begin
                    seq_d.phase = PH_DONE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase = seq_q.phase;

    // R6
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.phase == PH_SETUP) || (seq_q.phase == PH_RUN)) && start
        |=> (seq_q.phase != PH_SETUP));

endmodule

// File: rtl/qdm_digit_sel.sv
module qdm_digit_sel
    import qdm_pkg::*;
#(
    parameter int        K    = 8,
    parameter sel_mode_e MODE = SEL_TRIPLE
) (
    input  logic [1:0]          digit,
    input  logic                carry_in,
    input  logic [K-1:0]        a,
    input  logic [K+1:0]        three_a,
    output logic signed [K+3:0] addend,
    output logic                carry_out
);

    localparam int SW = K + 4;

    logic signed [SW-1:0] a_s, two_a_s, three_a_s;

    assign a_s       = $signed({4'b0000, a});
    assign two_a_s   = $signed({3'b000, a, 1'b0});
    assign three_a_s = $signed({2'b00, three_a});

    generate
        if (MODE == SEL_TRIPLE) begin : g_triple
            logic unused_carry;
            assign unused_carry = carry_in;
            always_comb begin
                carry_out = 1'b0;
                unique case (digit)
                    2'd0: addend = '0;
                    2'd1: addend = a_s;
                    2'd2: addend = two_a_s;
                    default: addend = three_a_s;
                endcase
            end
        end else begin : g_negate
            logic       unused_three;
            logic [2:0] eff;
            assign unused_three = ^three_a_s;
            assign eff = {1'b0, digit} + {2'b00, carry_in};
            always_comb begin
                unique case (eff)
                    3'd0: begin addend = '0;      carry_out = 1'b0; end
                    3'd1: begin addend = a_s;     carry_out = 1'b0; end
                    3'd2: begin addend = two_a_s; carry_out = 1'b0; end
                    3'd3: begin addend = -a_s;    carry_out = 1'b1; end
                    default: begin addend = '0;   carry_out = 1'b1; end
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/quad_digit_mult.sv
module quad_digit_mult #(
    parameter int                 K    = 8,
    parameter qdm_pkg::sel_mode_e MODE = qdm_pkg::SEL_TRIPLE
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [K-1:0]   a_in,
    input  logic [K-1:0]   x_in,
    output logic           done,
    output logic [2*K-1:0] product
);
    import qdm_pkg::*;

    localparam int NDIG = K / 2;
    localparam int AW   = K + 4;
    localparam int LW   = $clog2(NDIG + 2) + 1;

    typedef struct packed {
        logic [K-1:0]  a;
        logic [K+1:0]  three_a;
        logic [AW-1:0] hi;
        logic [K-1:0]  lo;
        logic          carry;
    } dp_t;

    dp_t dp_d, dp_q;

    phase_e               phase;
    logic                 accept, last_digit;
    logic signed [AW-1:0] addend, fix, sum;
    logic                 carry_out;

    qdm_seq #(.NDIG(NDIG)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .phase      (phase),
        .accept     (accept),
        .last_digit (last_digit)
    );

    qdm_digit_sel #(.K(K), .MODE(MODE)) u_sel (
        .digit     (dp_q.lo[1:0]),
        .carry_in  (dp_q.carry),
        .a         (dp_q.a),
        .three_a   (dp_q.three_a),
        .addend    (addend),
        .carry_out (carry_out)
    );

    // A carry left after the top digit is worth a*2^K; before the
    // final shift by two that is a*4 added to the upper part.
    assign fix = (last_digit && carry_out) ? $signed({2'b00, dp_q.a, 2'b00}) : '0;
    assign sum = $signed(dp_q.hi) + addend + fix;

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.a     = a_in;
            dp_d.lo    = x_in;
            dp_d.hi    = '0;
            dp_d.carry = 1'b0;
        end else if (phase == PH_SETUP) begin
            dp_d.three_a = {2'b00, dp_q.a} + {1'b0, dp_q.a, 1'b0};
        end else if (phase == PH_RUN) begin
            dp_d.hi    = $unsigned(sum >>> 2);
            dp_d.lo    = {sum[1:0], dp_q.lo[K-1:2]};
            dp_d.carry = carry_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign done    = (phase == PH_DONE);
    assign product = {dp_q.hi[K-1:0], dp_q.lo};

    // ---------------- checking logic ----------------
    logic [LW-1:0]  lat_q;
    logic [2*K-1:0] ref_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
            ref_q <= '0;
        end else if (accept) begin
            lat_q <= '0;
            ref_q <= a_in * x_in;
        end else if ((phase == PH_SETUP) || (phase == PH_RUN)) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (lat_q == LW'(NDIG + 1)));

    // R3 R4
    product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (product == ref_q));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dp_q.hi[AW-1:K] == '0));

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(product)));

    // R7
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);

endmodule

// File: tb/quad_digit_mult_bench.sv
module quad_digit_mult_bench;

    localparam int K    = 8;
    localparam int NDIG = K / 2;
    localparam int LAT_NEG = NDIG + 2;  // negedges counted from the one after the accepting edge

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [K-1:0]   a_in = '0;
    logic [K-1:0]   x_in = '0;
    logic           done_t, done_n;
    logic [2*K-1:0] prod_t, prod_n;

    int checks = 0;
    int fails  = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    quad_digit_mult #(.K(K), .MODE(qdm_pkg::SEL_TRIPLE)) u_quad_digit_mult (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .x_in(x_in),
        .done(done_t), .product(prod_t)
    );

    quad_digit_mult #(.K(K), .MODE(qdm_pkg::SEL_NEGATE)) u_quad_digit_mult_neg (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .x_in(x_in),
        .done(done_n), .product(prod_n)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] next_rand(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // Launch one product; optional disturbance during the run.
    // mode 0: none, 1: busy start with other operands (R6), 2: operand change (R8)
    task automatic run_op(input logic [K-1:0] a, input logic [K-1:0] x,
                          input int mode, input string req);
        int n;
        logic [2*K-1:0] exp;
        exp = a * x;
        @(negedge clk);
        a_in = a; x_in = x; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 done cleared after start (triple)", done_t, 0);
        chk("R7 done cleared after start (negate)", done_n, 0);
        if (mode == 2) begin
            a_in = ~a; x_in = x ^ 8'h5A;
        end
        n = 1;
        while (!done_t && n < 40) begin
            if (mode == 1 && n == 2) begin
                a_in = a + 8'd3; x_in = ~x; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk({"R2 latency ", req}, n, LAT_NEG);
        chk({"R2 negate mode done aligned ", req}, done_n, 1);
        chk({"R3 triple product ", req}, prod_t, exp);
        chk({"R4 negate product ", req}, prod_n, exp);
    endtask

    task automatic t_reset;
        chk("R1 reset done (triple)", done_t, 0);
        chk("R1 reset done (negate)", done_n, 0);
        chk("R1 reset product (triple)", prod_t, 0);
        chk("R1 reset product (negate)", prod_n, 0);
    endtask

    task automatic t_directed;
        run_op(8'd13, 8'd11, 0, "13x11");
        run_op(8'd200, 8'hFF, 0, "carry through all digits");
        run_op(8'd7, 8'hC0, 0, "top digit 3");
        run_op(8'd99, 8'hEE, 0, "digits 2 with carries");
        run_op(8'd1, 8'd3, 0, "low digit 3");
    endtask

    task automatic t_extremes;
        run_op(8'hFF, 8'hFF, 0, "R9 max x max");
        run_op(8'h00, 8'hFF, 0, "R9 zero multiplicand");
        run_op(8'hFF, 8'h00, 0, "R9 zero multiplier");
    endtask

    task automatic t_hold;
        logic [2*K-1:0] exp;
        run_op(8'd45, 8'd77, 0, "before hold");
        exp = 16'(45 * 77);
        repeat (6) @(negedge clk);
        chk("R5 done held (triple)", done_t, 1);
        chk("R5 done held (negate)", done_n, 1);
        chk("R5 product held (triple)", prod_t, exp);
        chk("R5 product held (negate)", prod_n, exp);
    endtask

    task automatic t_busy_start;
        run_op(8'd150, 8'd201, 1, "R6 start while busy ignored");
    endtask

    task automatic t_operand_change;
        run_op(8'd222, 8'd37, 2, "R8 operands changed after start");
    endtask

    task automatic t_sweep;
        logic [K-1:0] a, x;
        for (int i = 0; i < 250; i++) begin
            lfsr = next_rand(lfsr); a = lfsr[7:0];
            lfsr = next_rand(lfsr); x = lfsr[7:0];
            run_op(a, x, 0, "sweep");
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_directed();
        t_extremes();
        t_hold();
        t_busy_start();
        t_operand_change();
        t_sweep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule